// File: doc/BRIEF.md
# Per-Sink Trace ID Gate

The gate sits between trace sources and two trace buffer sinks and decides, beat by beat, which trace data each sink accepts. Every sink owns a 128-bit allow-mask in which each trace source ID has one bit. A beat on a sink's trace input is forwarded to that sink's output only if the mask bit for the beat's ID is set. Beats that are filtered out are still consumed, so a source is never held up by data that a sink does not want.

Software programs the masks through a small APB-style register port. The mask registers are write-protected by a key-based lock. The unit comes out of reset locked, and software opens it, updates the masks and closes it again. Reads work at all times. A few IDs are reserved and never reach any sink, whatever their mask bits say.

Top module: `trace_id_gate`

## Requirements
- R1: After reset every mask register reads 0, the lock-status register at 0xFB4 reads 1 (locked), and no beat reaches either sink output.
- R2: Trace ID n of sink s is bit (n mod 32) of the 32-bit mask register at byte address base(s) + 4*(n div 32), where base(0) = 0xF8 and base(1) = 0x108. Each sink's block spans 0x10 bytes, and every mask register reads back the value last written to it while unlocked.
- R3: A write of 0xC5ACCE55 to address 0xFB0 unlocks the unit, and a write of any other value there locks it. Bit 0 of the register at 0xFB4 reads 1 while locked and 0 while unlocked.
- R4: While locked, writes to mask registers leave them unchanged, and reads still return their contents.
- R5: A valid beat whose ID has its mask bit set appears on that sink's output in the same cycle, with the same data and ID. The input ready then follows the sink's output ready.
- R6: A valid beat whose ID has its mask bit clear does not raise the output valid, and its input ready is 1.
- R7: The two sinks filter independently. A bit set in one sink's mask has no effect on the other sink.
- R8: Beats with ID 0 or with IDs 0x70 to 0x7F are dropped as in R6, even when their mask bit is set.
- R9: A mask write takes effect from the first beat presented after the clock edge that completes the register access phase. Before that edge the old mask applies.
- R10: Reads from addresses outside the mask blocks and the lock-status register return 0. Writes there change no mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 1 | Register port select |
| regEnable | input | 1 | Register access phase |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 12 | Byte address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the current address |
| trcInData | input | 64 | Trace data per sink, sink s at [32s +: 32] |
| trcInId | input | 14 | Trace ID per sink, sink s at [7s +: 7] |
| trcInValid | input | 2 | Beat valid per sink |
| trcInReady | output | 2 | Beat accepted per sink |
| trcOutData | output | 64 | Forwarded data per sink |
| trcOutId | output | 14 | Forwarded ID per sink |
| trcOutValid | output | 2 | Forwarded beat valid per sink |
| trcOutReady | input | 2 | Sink ready per sink |

## Verification
The filter path is combinational, so a beat's verdict is due in the same cycle it is presented. The bench drives each beat on a falling edge and samples outputs and ready shortly afterwards. A mask or lock write lands on the rising edge that ends the access phase. It is visible on the read port and on the filter at the following falling edge, and that is where the bench samples. For the R9 case the bench holds one beat across the write and samples it twice: once with the access phase open but before its completing edge, where it must still be dropped, and once just after that edge, where it must pass.

// File: rtl/tidg_pkg.sv
package tidg_pkg;

  localparam int unsigned REG_W   = 32;
  localparam int unsigned IDX_W   = 4;

  // Strobes from the register control to the mask/filter datapath.
  typedef struct packed {
    logic             wrEn;   // commit wdata into the selected mask word
    logic [IDX_W-1:0] sink;   // selected sink
    logic [IDX_W-1:0] word;   // selected 32-bit word inside the sink mask
    logic [REG_W-1:0] wdata;
  } maskCtl_t;

endpackage

// File: rtl/tidg_ctrl.sv
module tidg_ctrl
  import tidg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned NUM_SINKS   = 2,
  parameter int unsigned WORDS       = 4,
  parameter int unsigned SINK_BASE   = 'hF8,
  parameter int unsigned SINK_STRIDE = 'h10,
  parameter int unsigned LOCK_ADDR   = 'hFB0,
  parameter int unsigned STAT_ADDR   = 'hFB4,
  parameter logic [31:0] UNLOCK_KEY  = 32'hC5ACCE55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regEnable,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic [REG_W-1:0]  maskRdata,
  output maskCtl_t          ctl
);

  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic             locked;
  logic             access;
  logic             lockWrite;
  logic             maskHit;
  logic [IDX_W-1:0] selSink;
  logic [IDX_W-1:0] selWord;

  assign access    = regSel && regEnable;
  assign lockWrite = access && regWrite && (regAddr == LOCK_A);

  // Address decode over every sink block and word.
  always_comb begin
    maskHit = 1'b0;
    selSink = '0;
    selWord = '0;
    for (int s = 0; s < int'(NUM_SINKS); s++) begin
      for (int w = 0; w < int'(WORDS); w++) begin
        if (regAddr == ADDR_W'(SINK_BASE + s * SINK_STRIDE + 4 * w)) begin
          maskHit = 1'b1;
          selSink = IDX_W'(s);
          selWord = IDX_W'(w);
        end
      end
    end
  end

  // Lock state: comes out of reset closed.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          locked <= 1'b1;
    else if (lockWrite) locked <= (regWdata != UNLOCK_KEY);
  end

  always_comb begin
    ctl.wrEn  = access && regWrite && maskHit && !locked;
    ctl.sink  = selSink;
    ctl.word  = selWord;
    ctl.wdata = regWdata;
  end

  always_comb begin
    if (maskHit)                regRdata = maskRdata;
    else if (regAddr == STAT_A) regRdata = {{(REG_W-1){1'b0}}, locked};
    else                        regRdata = '0;
  end

  // R3: the key opens the unit
  p_unlock_key_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lockWrite && regWdata == UNLOCK_KEY) |=> !locked);

  // R3: any other value closes it
  p_relock_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lockWrite && regWdata != UNLOCK_KEY) |=> locked);

  // R3: lock state moves only on a lock-register write
  p_lock_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !lockWrite |=> $stable(locked));

  // R10: a read outside every block returns zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!maskHit && regAddr != STAT_A) |-> (regRdata == '0));

endmodule

// File: rtl/tidg_path.sv
module tidg_path
  import tidg_pkg::*;
#(
  parameter int unsigned NUM_SINKS = 2,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ID_W      = 7,
  parameter int unsigned RSV_FLOOR = 'h70
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  maskCtl_t                    ctl,
  output logic [REG_W-1:0]            maskRdata,
  input  logic [NUM_SINKS*DATA_W-1:0] inData,
  input  logic [NUM_SINKS*ID_W-1:0]   inId,
  input  logic [NUM_SINKS-1:0]        inValid,
  output logic [NUM_SINKS-1:0]        inReady,
  output logic [NUM_SINKS*DATA_W-1:0] outData,
  output logic [NUM_SINKS*ID_W-1:0]   outId,
  output logic [NUM_SINKS-1:0]        outValid,
  input  logic [NUM_SINKS-1:0]        outReady
);

  localparam int unsigned MASK_BITS = 1 << ID_W;
  localparam int unsigned WORDS     = MASK_BITS / REG_W;

  logic [NUM_SINKS-1:0][WORDS-1:0][REG_W-1:0] maskq;

  // Mask storage, one register per sink word.
  for (genvar s = 0; s < int'(NUM_SINKS); s++) begin : g_store
    for (genvar w = 0; w < int'(WORDS); w++) begin : g_word
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          maskq[s][w] <= '0;
        else if (ctl.wrEn && int'(ctl.sink) == s && int'(ctl.word) == w)
          maskq[s][w] <= ctl.wdata;
      end
    end
  end

  always_comb begin
    maskRdata = '0;
    for (int s = 0; s < int'(NUM_SINKS); s++)
      for (int w = 0; w < int'(WORDS); w++)
        if (int'(ctl.sink) == s && int'(ctl.word) == w)
          maskRdata = maskq[s][w];
  end

  // Per-sink filter.
  for (genvar s = 0; s < int'(NUM_SINKS); s++) begin : g_filt
    logic [MASK_BITS-1:0] sinkMask;
    logic [ID_W-1:0]      beatId;
    logic                 reserved;
    logic                 allowed;

    assign sinkMask = maskq[s];
    assign beatId   = inId[s*ID_W +: ID_W];
    assign reserved = (beatId == '0) || (beatId >= ID_W'(RSV_FLOOR));
    assign allowed  = sinkMask[beatId] && !reserved;

    assign outValid[s]               = inValid[s] && allowed;
    assign outData[s*DATA_W +: DATA_W] = inData[s*DATA_W +: DATA_W];
    assign outId[s*ID_W +: ID_W]       = beatId;
    assign inReady[s]                = allowed ? outReady[s] : 1'b1;

    // R8: reserved IDs never leave
    p_reserved_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
      (inValid[s] && reserved) |-> !outValid[s]);

    // R6: a dropped beat is consumed
    p_drop_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
      (inValid[s] && !outValid[s]) |-> inReady[s]);

    // R5: a forwarded beat obeys sink backpressure
    p_pass_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
      outValid[s] |-> (inValid[s] && inReady[s] == outReady[s]));
  end

  // R4: masks move only on a committed write strobe
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.wrEn |=> $stable(maskq));

endmodule

// File: rtl/trace_id_gate.sv
module trace_id_gate
  import tidg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned NUM_SINKS   = 2,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ID_W        = 7,
  parameter int unsigned SINK_BASE   = 'hF8,
  parameter int unsigned SINK_STRIDE = 'h10,
  parameter int unsigned RSV_FLOOR   = 'h70
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regSel,
  input  logic                        regEnable,
  input  logic                        regWrite,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [31:0]                 regWdata,
  output logic [31:0]                 regRdata,
  input  logic [NUM_SINKS*DATA_W-1:0] trcInData,
  input  logic [NUM_SINKS*ID_W-1:0]   trcInId,
  input  logic [NUM_SINKS-1:0]        trcInValid,
  output logic [NUM_SINKS-1:0]        trcInReady,
  output logic [NUM_SINKS*DATA_W-1:0] trcOutData,
  output logic [NUM_SINKS*ID_W-1:0]   trcOutId,
  output logic [NUM_SINKS-1:0]        trcOutValid,
  input  logic [NUM_SINKS-1:0]        trcOutReady
);

  localparam int unsigned WORDS = (1 << ID_W) / REG_W;

  maskCtl_t         ctl;
  logic [REG_W-1:0] maskRdata;

  tidg_ctrl #(
    .ADDR_W(ADDR_W), .NUM_SINKS(NUM_SINKS), .WORDS(WORDS),
    .SINK_BASE(SINK_BASE), .SINK_STRIDE(SINK_STRIDE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regEnable(regEnable),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .maskRdata(maskRdata), .ctl(ctl)
  );

  tidg_path #(
    .NUM_SINKS(NUM_SINKS), .DATA_W(DATA_W), .ID_W(ID_W), .RSV_FLOOR(RSV_FLOOR)
  ) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .maskRdata(maskRdata),
    .inData(trcInData), .inId(trcInId), .inValid(trcInValid),
    .inReady(trcInReady), .outData(trcOutData), .outId(trcOutId),
    .outValid(trcOutValid), .outReady(trcOutReady)
  );

endmodule

// File: tb/trace_id_gate_test.sv
`timescale 1ns/1ps
module trace_id_gate_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 0, regEnable = 0, regWrite = 0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [63:0] trcInData = '0;
  logic [13:0] trcInId = '0;
  logic [1:0]  trcInValid = '0;
  logic [1:0]  trcInReady;
  logic [63:0] trcOutData;
  logic [13:0] trcOutId;
  logic [1:0]  trcOutValid;
  logic [1:0]  trcOutReady = 2'b11;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  trace_id_gate uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regSel = 1; regWrite = 1; regAddr = a; regWdata = d; regEnable = 0;
    @(negedge clk);
    regEnable = 1;
    @(negedge clk);
    regSel = 0; regEnable = 0; regWrite = 0;
  endtask

  task automatic regRd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regSel = 1; regWrite = 0; regAddr = a; regEnable = 0;
    @(negedge clk);
    regEnable = 1;
    #1 d = regRdata;
    @(negedge clk);
    regSel = 0; regEnable = 0;
  endtask

  // Present one beat on a sink (other sink idle) and sample after settle.
  task automatic beat(input int s, input logic [6:0] id, input logic [31:0] d);
    @(negedge clk);
    trcInValid = '0;
    trcInValid[s] = 1'b1;
    trcInId[s*7 +: 7] = id;
    trcInData[s*32 +: 32] = d;
    #1;
  endtask

  // {sink, id, expectPass}
  localparam logic [8:0] VEC [10] = '{
    {1'b0, 7'd5,   1'b1},   // R5 allowed on sink 0
    {1'b0, 7'd0,   1'b0},   // R8 id 0 reserved
    {1'b0, 7'd97,  1'b1},   // R2 word 3 bit 1
    {1'b0, 7'd112, 1'b0},   // R8 0x70 reserved
    {1'b0, 7'd35,  1'b0},   // R7 only sink 1 has 35
    {1'b1, 7'd35,  1'b1},   // R5 word 1 bit 3 of sink 1
    {1'b1, 7'd5,   1'b0},   // R7 only sink 0 has 5
    {1'b1, 7'd64,  1'b1},   // R2 word 2 bit 0
    {1'b0, 7'd6,   1'b0},   // R6 clear bit
    {1'b1, 7'd127, 1'b0}    // R8 top ID
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRd(12'hFB4, rd); chk("R1 lock status", rd, 1);
    regRd(12'hF8, rd);  chk("R1 mask zero", rd, 0);
    regRd(12'h114, rd); chk("R1 mask zero", rd, 0);
    beat(0, 7'd5, 32'hAAAA0001);
    chk("R1 no pass", trcOutValid, 0);
    chk("R6 ready on drop", trcInReady, 2'b11);

    // R4 locked write ignored
    regWr(12'hF8, 32'hFFFFFFFF);
    regRd(12'hF8, rd); chk("R4 locked write", rd, 0);

    // R3 unlock and program
    regWr(12'hFB0, 32'hC5ACCE55);
    regRd(12'hFB4, rd); chk("R3 unlocked status", rd, 0);
    regWr(12'hF8,  32'h0000_0021);
    regWr(12'h104, 32'h0001_0002);
    regWr(12'h10C, 32'h0000_0008);
    regWr(12'h110, 32'h0000_0001);
    regRd(12'h104, rd); chk("R2 readback s0w3", rd, 32'h0001_0002);
    regRd(12'h10C, rd); chk("R2 readback s1w1", rd, 32'h0000_0008);
    regRd(12'h108, rd); chk("R2 readback s1w0", rd, 0);

    // R10 unmapped
    regWr(12'h118, 32'hDEADBEEF);
    regRd(12'h118, rd); chk("R10 unmapped read", rd, 0);
    regRd(12'h200, rd); chk("R10 unmapped read", rd, 0);
    regRd(12'h114, rd); chk("R10 no stray write", rd, 0);

    // R3 relock with a wrong value
    regWr(12'hFB0, 32'h0);
    regRd(12'hFB4, rd); chk("R3 relocked status", rd, 1);
    regWr(12'h10C, 32'hFFFF);
    regRd(12'h10C, rd); chk("R4 locked write keeps", rd, 32'h8);

    // Vector table walk
    for (int i = 0; i < 10; i++) begin
      int s;
      logic [31:0] d;
      s = int'(VEC[i][8]);
      d = 32'h5000_0000 + 32'(i);
      beat(s, VEC[i][7:1], d);
      chk("R5/R6/R7/R8 valid", trcOutValid[s], VEC[i][0]);
      chk("R6 ready", trcInReady[s], 1'b1);
      chk("R7 other sink quiet", trcOutValid[1-s], 1'b0);
      if (VEC[i][0]) begin
        chk("R5 data", trcOutData[s*32 +: 32], d);
        chk("R5 id", trcOutId[s*7 +: 7], VEC[i][7:1]);
      end
    end

    // R5 backpressure
    trcOutReady = 2'b00;
    beat(1, 7'd64, 32'h1234);
    chk("R5 valid held", trcOutValid[1], 1'b1);
    chk("R5 ready follows sink", trcInReady[1], 1'b0);
    beat(1, 7'd65, 32'h1234);
    chk("R6 drop ignores backpressure", trcInReady[1], 1'b1);
    trcOutReady = 2'b11;

    // R9 timing of a mask update: hold id 36 on sink 1 across the write
    regWr(12'hFB0, 32'hC5ACCE55);
    beat(1, 7'd36, 32'h9999);
    chk("R9 before write", trcOutValid[1], 1'b0);
    @(negedge clk);
    regSel = 1; regWrite = 1; regAddr = 12'h10C; regWdata = 32'h18; regEnable = 0;
    @(negedge clk);
    regEnable = 1;
    #1 chk("R9 access phase not complete", trcOutValid[1], 1'b0);
    @(negedge clk);
    regSel = 0; regEnable = 0; regWrite = 0;
    #1 chk("R9 after completing edge", trcOutValid[1], 1'b1);
    chk("R9 data", trcOutData[63:32], 32'h9999);

    // R1 reset clears again
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    #1 chk("R1 reset clears mask", trcOutValid[1], 1'b0);
    regRd(12'h10C, rd); chk("R1 mask after reset", rd, 0);
    regRd(12'hFB4, rd); chk("R1 locked after reset", rd, 1);

    trcInValid = '0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule